// File: doc/BRIEF.md
# Two-Level Interrupt Register Aggregator

This block collects single-cycle interrupt events into a set of leaf register groups and folds their enabled pending state into one master register that drives a single interrupt line. Each leaf group has four 32-bit registers: a status register that shows the raw events of the previous cycle, a mask register that decides which events are latched, an identity register that remembers accepted events until software clears them, and an enable register that selects which remembered events count towards the master.

A fixed-at-build map ties each master bit to the leaf groups. Each map entry names a leaf group, a master bit and a bitmask over that group. Several entries may target the same master bit. The top bit of the master register is the only bit software can write, and it acts as the global enable for the interrupt output. Software reaches all registers through a simple word-aligned write strobe and a combinational read port.

Top module: `irq_aggregator`

## Requirements
- R1: Leaf group g occupies byte addresses g*0x10 to g*0x10+0xC. Its status register is at offset 0x0, mask at 0x4, identity at 0x8 and enable at 0xC. Any aligned address at NUM_GROUPS*0x10 or in the 16 bytes that follow selects the master register. Accesses with addr[1:0] not zero are ignored. Reads return the value in the same cycle, and unmapped addresses read as zero.
- R2: An event pulse (evt_valid high, with a group number and a bit number) sets the selected identity bit at the next clock edge when the matching mask bit is 0. An event that names a group number of NUM_GROUPS or more is discarded.
- R3: An event whose mask bit is 1 leaves the identity register unchanged, and it is not recorded later when the mask bit is cleared.
- R4: A write to an identity register clears each bit written as 1 and keeps each bit written as 0.
- R5: A write to a mask or enable register replaces its whole value.
- R6: Master bit b (b < 31) is 1 when, for at least one map entry targeting b, (identity AND enable of the entry's group) AND the entry's bitmask is nonzero. Otherwise it is 0. The default map is: group 0 mask 0x0000FFFF to bit 0; group 0 mask 0xFFFF0000 to bit 1; group 1 mask 0x0000FFFF to bit 2; group 1 mask 0xFFFF0000 to bit 3; group 2 mask 0x0000FFFF to bit 4; group 3 mask 0x0000FFFF to bit 6; group 4 all bits to bit 16; group 5 all bits to bit 17.
- R7: A master write stores only bit 31 as the global enable. Writes to bits 30..0 of the master register have no effect.
- R8: irq_out is 1 exactly when master bit 31 is 1 and at least one of master bits 30..0 is 1.
- R9: A status register reads as a one-hot value of the event accepted for that group at the last clock edge, ignoring the mask, or zero if there was none. Writes to status registers have no effect.
- R10: After reset every register reads as zero and irq_out is 0.
- R11: When an event and an identity write-1-to-clear hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (7) | Byte address for reads and writes |
| wr_data | input | REG_W (32) | Write data |
| rd_data | output | REG_W (32) | Read data for addr, combinational |
| evt_valid | input | 1 | Event pulse, one cycle |
| evt_group | input | GRP_W (3) | Leaf group of the event |
| evt_bit | input | BIT_W (5) | Bit position of the event within its group |
| irq_out | output | 1 | Aggregated interrupt output |

## Verification
Directed sequences cover the cases that separate similar faulty designs. A masked event is later unmasked, to show that it was not stored. An event and a clear land on the same bit in the same cycle. A write to the master register carries ones in its read-only bits. Two map entries share one group but use different halves, so the test can tell whether the per-entry bitmask is applied or only a group-wide OR. After that, a random mix of writes to every register type (master included), events on valid and invalid groups, and sparse masks and enables is compared against a bench model. This finds wrong field updates, wrong offset decoding, and summaries that go stale after identity or enable changes.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   localparam int WORD_W = 32;

   // register selector inside one leaf group, taken from addr[3:2]
   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_MASK   = 2'd1,
      SEL_IDENT  = 2'd2,
      SEL_ENABLE = 2'd3
   } leaf_sel_e;

   // default routing table, entry 0 in the lowest slice
   localparam int DEF_MAP_N = 8;
   localparam logic [DEF_MAP_N-1:0][7:0] DEF_MAP_GRP =
      {8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd1, 8'd0, 8'd0};
   localparam logic [DEF_MAP_N-1:0][7:0] DEF_MAP_BIT =
      {8'd17, 8'd16, 8'd6, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0};
   localparam logic [DEF_MAP_N-1:0][WORD_W-1:0] DEF_MAP_MASK =
      {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_FFFF,
       32'hFFFF_0000, 32'h0000_FFFF, 32'hFFFF_0000, 32'h0000_FFFF};

endpackage

// File: rtl/irq_leaf_group.sv
module irq_leaf_group import irq_agg_pkg::*; #(
   parameter int W = 32,
   localparam int BIT_W = $clog2(W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_sel,
   input  leaf_sel_e        reg_sel,
   input  logic [W-1:0]     wr_data,
   input  logic             evt_hit,
   input  logic [BIT_W-1:0] evt_bit,
   output logic [W-1:0]     status_q,
   output logic [W-1:0]     mask_q,
   output logic [W-1:0]     ident_q,
   output logic [W-1:0]     enable_q,
   output logic [W-1:0]     pending
);

   logic [W-1:0] evt_vec;
   logic [W-1:0] accept_vec;
   logic [W-1:0] clear_vec;

   assign evt_vec    = evt_hit ? ({{(W-1){1'b0}}, 1'b1} << evt_bit) : '0;
   assign accept_vec = evt_vec & ~mask_q;
   assign clear_vec  = (wr_sel && reg_sel == SEL_IDENT) ? wr_data : '0;
   assign pending    = ident_q & enable_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= '0;
         ident_q  <= '0;
         enable_q <= '0;
      end else begin
         status_q <= evt_vec;
         // a new event overrides a clear of the same bit
         ident_q  <= (ident_q & ~clear_vec) | accept_vec;
         if (wr_sel && reg_sel == SEL_MASK)   mask_q   <= wr_data;
         if (wr_sel && reg_sel == SEL_ENABLE) enable_q <= wr_data;
      end
   end

endmodule

// File: rtl/irq_master_map.sv
module irq_master_map #(
   parameter int W = 32,
   parameter int NUM_GROUPS = 6,
   parameter int MAP_N = 8,
   parameter logic [MAP_N-1:0][7:0]   MAP_GRP  = '0,
   parameter logic [MAP_N-1:0][7:0]   MAP_BIT  = '0,
   parameter logic [MAP_N-1:0][W-1:0] MAP_MASK = '0
) (
   input  logic [NUM_GROUPS-1:0][W-1:0] pending,
   output logic [W-2:0]                 sum_bits
);

   function automatic logic [MAP_N-1:0] entries_for(input int b);
      logic [MAP_N-1:0] sel;
      sel = '0;
      for (int e = 0; e < MAP_N; e++)
         if (int'(MAP_BIT[e]) == b) sel[e] = 1'b1;
      return sel;
   endfunction

   logic [MAP_N-1:0] entry_hit;

   for (genvar e = 0; e < MAP_N; e++) begin : g_entry
      localparam int GSRC = int'(MAP_GRP[e]);
      if (GSRC >= NUM_GROUPS)
         $error("map entry %0d names a missing group", e);
      if (int'(MAP_BIT[e]) >= W - 1)
         $error("map entry %0d targets the enable bit or beyond", e);
      assign entry_hit[e] = |(pending[GSRC] & MAP_MASK[e]);
   end

   for (genvar b = 0; b < W - 1; b++) begin : g_bit
      localparam logic [MAP_N-1:0] SEL = entries_for(b);
      assign sum_bits[b] = |(entry_hit & SEL);
   end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator import irq_agg_pkg::*; #(
   parameter int NUM_GROUPS = 6,
   parameter int REG_W = WORD_W,
   parameter int MAP_N = DEF_MAP_N,
   parameter logic [MAP_N-1:0][7:0]       MAP_GRP  = DEF_MAP_GRP,
   parameter logic [MAP_N-1:0][7:0]       MAP_BIT  = DEF_MAP_BIT,
   parameter logic [MAP_N-1:0][REG_W-1:0] MAP_MASK = DEF_MAP_MASK,
   localparam int ADDR_W = $clog2((NUM_GROUPS + 1) * 16),
   localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
   localparam int BIT_W  = $clog2(REG_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic              evt_valid,
   input  logic [GRP_W-1:0]  evt_group,
   input  logic [BIT_W-1:0]  evt_bit,
   output logic              irq_out
);

   localparam int AGW = ADDR_W - 4;

   if (REG_W < 8 || (REG_W & (REG_W - 1)) != 0)
      $error("REG_W must be a power of two of at least 8");
   if (NUM_GROUPS < 1)
      $error("NUM_GROUPS must be at least 1");

   logic [AGW-1:0] addr_grp;
   leaf_sel_e      reg_sel;
   logic           aligned;
   logic           is_master;
   logic           master_en_q;
   logic [REG_W-2:0] sum_bits;

   logic [NUM_GROUPS-1:0][REG_W-1:0] status_all;
   logic [NUM_GROUPS-1:0][REG_W-1:0] mask_all;
   logic [NUM_GROUPS-1:0][REG_W-1:0] ident_all;
   logic [NUM_GROUPS-1:0][REG_W-1:0] enable_all;
   logic [NUM_GROUPS-1:0][REG_W-1:0] pending_all;

   assign addr_grp  = addr[ADDR_W-1:4];
   assign reg_sel   = leaf_sel_e'(addr[3:2]);
   assign aligned   = (addr[1:0] == 2'b00);
   assign is_master = aligned && (addr_grp == AGW'(NUM_GROUPS));

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_leaf
      logic grp_wr;
      logic grp_evt;
      assign grp_wr  = wr_en && aligned && (addr_grp == AGW'(g));
      assign grp_evt = evt_valid && (evt_group == GRP_W'(g));

      irq_leaf_group #(.W(REG_W)) leaf_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_sel   (grp_wr),
         .reg_sel  (reg_sel),
         .wr_data  (wr_data),
         .evt_hit  (grp_evt),
         .evt_bit  (evt_bit),
         .status_q (status_all[g]),
         .mask_q   (mask_all[g]),
         .ident_q  (ident_all[g]),
         .enable_q (enable_all[g]),
         .pending  (pending_all[g])
      );
   end

   irq_master_map #(
      .W          (REG_W),
      .NUM_GROUPS (NUM_GROUPS),
      .MAP_N      (MAP_N),
      .MAP_GRP    (MAP_GRP),
      .MAP_BIT    (MAP_BIT),
      .MAP_MASK   (MAP_MASK)
   ) map_i (
      .pending  (pending_all),
      .sum_bits (sum_bits)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  master_en_q <= 1'b0;
      else if (wr_en && is_master) master_en_q <= wr_data[REG_W-1];
   end

   assign irq_out = master_en_q & (|sum_bits);

   always_comb begin
      rd_data = '0;
      if (is_master) rd_data = {master_en_q, sum_bits};
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (aligned && addr_grp == AGW'(g)) begin
            case (reg_sel)
               SEL_STATUS: rd_data = status_all[g];
               SEL_MASK:   rd_data = mask_all[g];
               SEL_IDENT:  rd_data = ident_all[g];
               SEL_ENABLE: rd_data = enable_all[g];
               default:    rd_data = '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
   parameter int NUM_GROUPS = 6,
   parameter int REG_W = 32,
   parameter int ADDR_W = 7,
   parameter int GRP_W = 3,
   parameter int BIT_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [REG_W-1:0]  wr_data,
   input logic              evt_valid,
   input logic [GRP_W-1:0]  evt_group,
   input logic [BIT_W-1:0]  evt_bit,
   input logic              irq_out,
   input logic              master_en,
   input logic [NUM_GROUPS-1:0][REG_W-1:0] mask_all,
   input logic [NUM_GROUPS-1:0][REG_W-1:0] ident_all
);

   logic evt_ok;
   logic master_wr;
   logic ident_wr;

   assign evt_ok    = evt_valid && (int'(evt_group) < NUM_GROUPS);
   assign master_wr = wr_en && addr[1:0] == 2'b00 && int'(addr[ADDR_W-1:4]) == NUM_GROUPS;
   assign ident_wr  = wr_en && addr[1:0] == 2'b00 && addr[3:2] == 2'd2
                      && int'(addr[ADDR_W-1:4]) < NUM_GROUPS;

   // R7
   master_en_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      master_wr |=> master_en == $past(wr_data[REG_W-1]));

   // R8
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> master_en);

   // R2
   event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_ok && !mask_all[evt_group][evt_bit])
      |=> ident_all[$past(evt_group)][$past(evt_bit)]);

   // R3
   masked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_ok && mask_all[evt_group][evt_bit] && !ident_all[evt_group][evt_bit] && !wr_en)
      |=> !ident_all[$past(evt_group)][$past(evt_bit)]);

   // R4
   ident_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ident_wr && !evt_valid)
      |=> (ident_all[$past(addr[ADDR_W-1:4])] & $past(wr_data)) == '0);

endmodule

bind irq_aggregator irq_aggregator_chk #(
   .NUM_GROUPS (NUM_GROUPS),
   .REG_W      (REG_W),
   .ADDR_W     (ADDR_W),
   .GRP_W      (GRP_W),
   .BIT_W      (BIT_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .addr      (addr),
   .wr_data   (wr_data),
   .evt_valid (evt_valid),
   .evt_group (evt_group),
   .evt_bit   (evt_bit),
   .irq_out   (irq_out),
   .master_en (master_en_q),
   .mask_all  (mask_all),
   .ident_all (ident_all)
);

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NG = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [6:0]  addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        evt_valid = 1'b0;
   logic [2:0]  evt_group = '0;
   logic [4:0]  evt_bit = '0;
   logic        irq_out;

   int n_tests = 0;
   int n_fail = 0;
   bit done = 0;

   logic [31:0] m_stat [NG];
   logic [31:0] m_mask [NG];
   logic [31:0] m_ident[NG];
   logic [31:0] m_en   [NG];
   logic        m_men;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_aggregator dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .evt_valid(evt_valid),
      .evt_group(evt_group), .evt_bit(evt_bit), .irq_out(irq_out)
   );

   // routing table as stated in R6
   function automatic logic [30:0] exp_sum();
      int          grp[8] = '{0, 0, 1, 1, 2, 3, 4, 5};
      int          tgt[8] = '{0, 1, 2, 3, 4, 6, 16, 17};
      logic [31:0] msk[8] = '{32'h0000FFFF, 32'hFFFF0000, 32'h0000FFFF, 32'hFFFF0000,
                              32'h0000FFFF, 32'h0000FFFF, 32'hFFFFFFFF, 32'hFFFFFFFF};
      logic [30:0] s = '0;
      for (int e = 0; e < 8; e++)
         if ((m_ident[grp[e]] & m_en[grp[e]] & msk[e]) != 0) s[tgt[e]] = 1'b1;
      return s;
   endfunction

   function automatic logic [31:0] exp_read(input logic [6:0] a);
      int g = int'(a[6:4]);
      if (a[1:0] != 0) return '0;
      if (g == NG) return {m_men, exp_sum()};
      if (g > NG) return '0;
      case (a[3:2])
         2'd0: return m_stat[g];
         2'd1: return m_mask[g];
         2'd2: return m_ident[g];
         default: return m_en[g];
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_rd(input string tag, input logic [6:0] a);
      addr = a;
      #1;
      check(tag, rd_data, exp_read(a));
   endtask

   task automatic check_irq(input string tag);
      check(tag, {31'b0, irq_out}, {31'b0, m_men & (|exp_sum())});
   endtask

   // one clock: optional write and optional event, model updated alongside
   task automatic step(input logic wr, input logic [6:0] a, input logic [31:0] d,
                       input logic ev, input logic [2:0] g, input logic [4:0] b);
      logic [31:0] acc = '0;
      int ga = int'(a[6:4]);
      wr_en = wr; addr = a; wr_data = d;
      evt_valid = ev; evt_group = g; evt_bit = b;
      if (ev && int'(g) < NG && !m_mask[g][b]) acc = 32'h1 << b;
      for (int k = 0; k < NG; k++) m_stat[k] = (ev && int'(g) == k) ? (32'h1 << b) : '0;
      if (wr && a[1:0] == 0) begin
         if (ga == NG) m_men = d[31];
         else if (ga < NG) begin
            case (a[3:2])
               2'd1: m_mask[ga] = d;
               2'd2: m_ident[ga] = m_ident[ga] & ~d;
               2'd3: m_en[ga] = d;
               default: ;
            endcase
         end
      end
      if (int'(g) < NG) m_ident[g] = m_ident[g] | acc;
      @(posedge clk);
      #1;
      wr_en = 1'b0; evt_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int k = 0; k < NG; k++) begin
         m_stat[k] = '0; m_mask[k] = '0; m_ident[k] = '0; m_en[k] = '0;
      end
      m_men = 1'b0;
      #(CLK_PERIOD * 3);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R10: reset contents
      for (int a = 0; a < 112; a += 4) check_rd("R10 reset read", 7'(a));
      check_irq("R10 reset irq");

      // R1 / R5: offsets and whole-value writes
      step(1, 7'h24, 32'hA5A5_0000, 0, 0, 0);
      step(1, 7'h2C, 32'h0F0F_0F0F, 0, 0, 0);
      check_rd("R5 mask g2", 7'h24);
      check_rd("R1 enable g2 offset", 7'h2C);
      check_rd("R1 ident g2 untouched", 7'h28);
      step(1, 7'h26, 32'hFFFF_FFFF, 0, 0, 0);
      check_rd("R1 unaligned write ignored", 7'h24);
      step(1, 7'h24, 32'h0000_0001, 0, 0, 0);
      check_rd("R5 mask replaced", 7'h24);

      // R2: accepted event, then R9 status view
      step(0, 0, 0, 1, 3'd0, 5'd3);
      check_rd("R9 status after event", 7'h00);
      check_rd("R2 ident latched", 7'h08);
      step(1, 7'h00, 32'hFFFF_FFFF, 0, 0, 0);
      check_rd("R9 status write ignored", 7'h00);
      check_rd("R2 ident kept", 7'h08);
      step(0, 0, 0, 1, 3'd7, 5'd2);
      check_rd("R2 bad group dropped", 7'h08);

      // R3: masked event is forgotten
      step(1, 7'h14, 32'h0000_0020, 0, 0, 0);
      step(0, 0, 0, 1, 3'd1, 5'd5);
      check_rd("R9 status ignores mask", 7'h10);
      check_rd("R3 masked dropped", 7'h18);
      step(1, 7'h14, 32'h0, 0, 0, 0);
      check_rd("R3 not recorded on unmask", 7'h18);

      // R4: write-1-to-clear
      step(0, 0, 0, 1, 3'd0, 5'd0);
      step(1, 7'h08, 32'h0000_0008, 0, 0, 0);
      check_rd("R4 partial clear", 7'h08);

      // R11: event beats clear on same bit
      step(1, 7'h08, 32'h0000_0001, 1, 3'd0, 5'd0);
      check_rd("R11 event wins", 7'h08);

      // R6 / R7 / R8: master aggregation
      step(1, 7'h0C, 32'h0000_0001, 0, 0, 0);
      check_rd("R6 bit0 summary", 7'h60);
      check_irq("R8 gated off");
      step(1, 7'h60, 32'hFFFF_FFFF, 0, 0, 0);
      check_rd("R7 only enable stored", 7'h60);
      check_irq("R8 irq on");
      step(1, 7'h5C, 32'hFFFF_FFFF, 0, 0, 0);
      step(0, 0, 0, 1, 3'd5, 5'd31);
      check_rd("R6 full group bit17", 7'h60);
      step(1, 7'h0C, 32'h0010_0000, 0, 0, 0);
      step(0, 0, 0, 1, 3'd0, 5'd20);
      check_rd("R6 high half only", 7'h60);
      step(1, 7'h08, 32'hFFFF_FFFF, 0, 0, 0);
      step(1, 7'h58, 32'hFFFF_FFFF, 0, 0, 0);
      check_rd("R6 cleared summary", 7'h60);
      check_irq("R8 no pending");
      step(1, 7'h6C, 32'h0000_0000, 0, 0, 0);
      check_rd("R7 master window write", 7'h60);

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [6:0]  ra = 7'((($urandom % 7) << 4) | (($urandom % 4) << 2));
         logic [31:0] rd = ($urandom % 2) ? ($urandom & $urandom & $urandom) : $urandom;
         step(($urandom % 3) != 0, ra, rd, ($urandom % 2) == 1,
              3'($urandom % 7), 5'($urandom % 32));
         check_irq("R8 random irq");
         check_rd("R6 random master", 7'h60);
         for (int r = 0; r < 2; r++)
            check_rd("R1 random read", 7'((($urandom % 7) << 4) | (($urandom % 4) << 2)));
      end

      finish_run();
   end

endmodule